// File: doc/BRIEF.md
# CD Audio Sample Serializer

This block turns a stream of 16-bit stereo sample pairs into a three-wire serial audio link: a bit clock, a channel-select clock and one serial data line. A fourth output carries an error flag for each sample, marking samples that could not be corrected. The flag is aligned with the data slot it describes. Each channel occupies a 24-bit-clock slot. The sample goes out most significant bit first in the first 16 positions, and the remaining 8 positions are driven to zero. One stereo frame is therefore 48 bit clocks long, with the left channel sent first.

The bit clock is derived from the faster system clock by a parameterised divider. At a 33.8688 MHz system clock and the default divider, it runs at 2.1168 MHz, which is 44.1 kHz × 2 × 24. Data, channel select and the error flag change only on the falling bit-clock edge, so a receiver samples on the rising edge. The channel-select level switches one bit clock before the first bit of the slot it announces.

A one-entry holding register accepts pairs through a valid/ready handshake. At each frame boundary the held pair is moved into the shifter. If no pair is waiting, the previous pair is sent again and an underrun output is raised for that frame.

Top module: `cd_audio_serializer`

## Requirements
- R1: `bclk_o` toggles every `CLK_DIV` system clocks, giving a period of 2·`CLK_DIV` cycles with equal high and low times.
- R2: `sdata_o` changes only in the cycle in which `bclk_o` falls.
- R3: Let positions 0..47 count the bit clocks of a frame. `lrck_o` is high at positions 47 and 0..22 and low at positions 23..46, and it changes only when `bclk_o` falls.
- R4: At slot offsets 0..15, the bit sent is sample bit 15 down to bit 0, unchanged in two's complement. Slot offsets 16..23 carry 0.
- R5: Positions 0..23 carry the left sample and positions 24..47 carry the right sample of the same pair.
- R6: `errflag_o` equals the left flag at positions 0..23 and the right flag at positions 24..47, and it changes only when `bclk_o` falls.
- R7: `in_ready` is high exactly when the holding register is empty. A pair is accepted in a cycle with `in_valid` and `in_ready` both high, and `in_ready` is low in the following cycle.
- R8: The held pair is loaded at the falling bit-clock edge that starts position 0, which frees the holding register. Pairs go out in the order they were accepted.
- R9: If no pair is held at that edge, the previous pair, including its flags, is sent again. `underrun_o` is then high for positions 0..47 of that frame. It is low during frames that carry a fresh pair.
- R10: A pair accepted in the same cycle as a frame load is not used by that frame. That frame is an underrun, and the pair goes out in the next frame.
- R11: After reset, `bclk_o`=0, `lrck_o`=1, `sdata_o`=0, `errflag_o`=0, `underrun_o`=0 and `in_ready`=1. The first rising bit-clock edge is position 47, and the repeated pair before any input is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding register empty |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| in_err_left | input | 1 | Left sample uncorrectable |
| in_err_right | input | 1 | Right sample uncorrectable |
| bclk_o | output | 1 | Serial bit clock |
| lrck_o | output | 1 | Channel select, high = left |
| sdata_o | output | 1 | Serial data, MSB first |
| errflag_o | output | 1 | Error flag of the current slot |
| underrun_o | output | 1 | Current frame repeats the previous pair |

## Verification
Two functions can fall in the same system-clock cycle: accepting a new pair into the empty holding register, and the frame-boundary load that reads that register. The bench watches for the rising bit-clock edge at position 47 and counts off the cycles to the falling edge that follows. It then presents a pair so that the handshake completes exactly on the load edge. The outcome is judged by expecting that frame to repeat the old pair with `underrun_o` high, and the next frame to carry the new pair with `underrun_o` low. A reference model decides frame by frame, using the acceptance cycle of each pair, which pair every frame must carry.

// File: rtl/cdser_pkg.sv
package cdser_pkg;

  // Channel-select levels on the serial link
  typedef enum logic {
    SEL_RIGHT = 1'b0,
    SEL_LEFT  = 1'b1
  } chan_sel_e;

  // Nominal slot geometry of the link
  localparam int unsigned DEF_SAMPLE_W = 16;
  localparam int unsigned DEF_SLOT_W   = 24;

endpackage

// File: rtl/cdser_clkgen.sv
module cdser_clkgen #(
  parameter int unsigned CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic bclk,
  output logic fall_tick
);

  localparam int unsigned CW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] TERM = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          term;

  assign term      = (cnt_q == TERM);
  assign fall_tick = term && bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bclk  <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      bclk  <= ~bclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cdser_holdbuf.sv
module cdser_holdbuf #(
  parameter int unsigned W = 34
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         pend_valid,
  output logic [W-1:0] pend_data
);

  logic full_q;

  assign in_ready   = ~full_q;
  assign pend_valid = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= 1'b0;
      pend_data <= '0;
    end else begin
      if (take) full_q <= 1'b0;
      if (in_valid && !full_q) begin
        full_q    <= 1'b1;
        pend_data <= in_data;
      end
    end
  end

endmodule

// File: rtl/cdser_framer.sv
module cdser_framer
  import cdser_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SLOT_W   = DEF_SLOT_W,
  parameter int unsigned W        = 2 * SAMPLE_W + 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fall_tick,
  input  logic         pend_valid,
  input  logic [W-1:0] pend_data,
  output logic         take,
  output logic         lrck,
  output logic         sdata,
  output logic         errf,
  output logic         underrun
);

  localparam int unsigned FRAME_W = 2 * SLOT_W;
  localparam int unsigned PAD_W   = SLOT_W - SAMPLE_W;
  localparam int unsigned PW      = $clog2(FRAME_W);
  localparam logic [PW-1:0] LAST_POS  = PW'(FRAME_W - 1);
  localparam logic [PW-1:0] RIGHT_POS = PW'(SLOT_W);
  localparam logic [PW-1:0] SWAP_POS  = PW'(SLOT_W - 1);

  logic [PW-1:0]      pos_q;
  logic [PW-1:0]      nxt_pos;
  logic [FRAME_W-1:0] shreg_q;
  logic [FRAME_W-1:0] frame_word;
  logic [W-1:0]       cur_q;
  logic [W-1:0]       nxt_pair;
  logic               wrap;

  logic [SAMPLE_W-1:0] nxt_left;
  logic [SAMPLE_W-1:0] nxt_right;
  logic                cur_err_r;

  assign wrap      = (pos_q == LAST_POS);
  assign nxt_pos   = wrap ? '0 : pos_q + 1'b1;
  assign take      = fall_tick && wrap && pend_valid;
  assign nxt_pair  = pend_valid ? pend_data : cur_q;
  assign nxt_left  = nxt_pair[SAMPLE_W-1:0];
  assign nxt_right = nxt_pair[2*SAMPLE_W-1:SAMPLE_W];
  assign cur_err_r = cur_q[2*SAMPLE_W+1];

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_word = {nxt_left, {PAD_W{1'b0}}, nxt_right, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign frame_word = {nxt_left, nxt_right};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= LAST_POS;
      shreg_q  <= '0;
      cur_q    <= '0;
      lrck     <= SEL_LEFT;
      sdata    <= 1'b0;
      errf     <= 1'b0;
      underrun <= 1'b0;
    end else if (fall_tick) begin
      pos_q <= nxt_pos;
      lrck  <= ((nxt_pos < SWAP_POS) || (nxt_pos == LAST_POS)) ? SEL_LEFT : SEL_RIGHT;
      if (wrap) begin
        cur_q    <= nxt_pair;
        underrun <= ~pend_valid;
        sdata    <= frame_word[FRAME_W-1];
        shreg_q  <= frame_word << 1;
        errf     <= nxt_pair[2*SAMPLE_W];
      end else begin
        sdata   <= shreg_q[FRAME_W-1];
        shreg_q <= shreg_q << 1;
        if (nxt_pos == RIGHT_POS) errf <= cur_err_r;
      end
    end
  end

endmodule

// File: rtl/cd_audio_serializer.sv
module cd_audio_serializer
  import cdser_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 8,
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SLOT_W   = DEF_SLOT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  input  logic                in_err_left,
  input  logic                in_err_right,
  output logic                bclk_o,
  output logic                lrck_o,
  output logic                sdata_o,
  output logic                errflag_o,
  output logic                underrun_o
);

  localparam int unsigned PAIR_W = 2 * SAMPLE_W + 2;

  logic              fall_tick;
  logic              take;
  logic              pend_valid;
  logic [PAIR_W-1:0] pend_data;
  logic [PAIR_W-1:0] in_pair;

  assign in_pair = {in_err_right, in_err_left, in_right, in_left};

  cdser_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk_o),
    .fall_tick (fall_tick)
  );

  cdser_holdbuf #(.W(PAIR_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_pair),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_data  (pend_data)
  );

  cdser_framer #(
    .SAMPLE_W (SAMPLE_W),
    .SLOT_W   (SLOT_W),
    .W        (PAIR_W)
  ) u_framer (
    .clk        (clk),
    .rst        (rst),
    .fall_tick  (fall_tick),
    .pend_valid (pend_valid),
    .pend_data  (pend_data),
    .take       (take),
    .lrck       (lrck_o),
    .sdata      (sdata_o),
    .errf       (errflag_o),
    .underrun   (underrun_o)
  );

endmodule

// File: rtl/cd_audio_serializer_chk.sv
module cd_audio_serializer_chk #(
  parameter int unsigned CLK_DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic bclk_o,
  input logic lrck_o,
  input logic sdata_o,
  input logic errflag_o,
  input logic underrun_o
);

  int unsigned gap_q;
  logic        prev_bclk;
  logic        bclk_chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= 0;
      prev_bclk <= 1'b0;
    end else begin
      prev_bclk <= bclk_o;
      gap_q     <= (bclk_o != prev_bclk) ? 1 : gap_q + 1;
    end
  end

  assign bclk_chg = (bclk_o != prev_bclk);

  // R1
  bclk_period_chk: assert property (@(posedge clk) disable iff (rst)
    bclk_chg |-> (gap_q == CLK_DIV));

  // R1
  bclk_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (gap_q == CLK_DIV) |-> bclk_chg);

  // R2
  sdata_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (sdata_o != $past(sdata_o)) |-> (!bclk_o && $past(bclk_o)));

  // R3
  lrck_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (lrck_o != $past(lrck_o)) |-> (!bclk_o && $past(bclk_o)));

  // R6
  errflag_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (errflag_o != $past(errflag_o)) |-> (!bclk_o && $past(bclk_o)));

  // R9
  underrun_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun_o != $past(underrun_o)) |-> (!bclk_o && $past(bclk_o)));

  // R7
  accept_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

endmodule

bind cd_audio_serializer cd_audio_serializer_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .bclk_o     (bclk_o),
  .lrck_o     (lrck_o),
  .sdata_o    (sdata_o),
  .errflag_o  (errflag_o),
  .underrun_o (underrun_o)
);

// File: tb/test_cd_audio_serializer.sv
`timescale 1ns/1ps
module test_cd_audio_serializer;

  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_left = '0;
  logic [15:0] in_right = '0;
  logic        in_err_left = 1'b0;
  logic        in_err_right = 1'b0;
  logic        bclk_o, lrck_o, sdata_o, errflag_o, underrun_o;

  cd_audio_serializer #(.CLK_DIV(DIV)) i_cd_audio_serializer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right),
    .in_err_left(in_err_left), .in_err_right(in_err_right),
    .bclk_o(bclk_o), .lrck_o(lrck_o), .sdata_o(sdata_o),
    .errflag_o(errflag_o), .underrun_o(underrun_o)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [15:0] l;
    logic [15:0] r;
    logic        el;
    logic        er;
    int          c;
  } ent_t;

  ent_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  // monitor state
  int          pos = 46;
  int          rise_cyc = -1;
  logic        prev_bclk = 1'b0;
  int          gap = 0;
  bit          gap_seen = 0;
  logic [15:0] cur_l = '0, cur_r = '0;
  logic        cur_el = 1'b0, cur_er = 1'b0;
  logic        exp_und = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic exp_sd(logic [15:0] l, logic [15:0] r, int p);
    logic [15:0] s;
    int b;
    s = (p < 24) ? l : r;
    b = p % 24;
    return (b < 16) ? s[15-b] : 1'b0;
  endfunction

  function automatic logic exp_lr(int p);
    return (p < 23) || (p == 47);
  endfunction

  function automatic logic exp_er(logic el, logic er, int p);
    return (p < 24) ? el : er;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (pos %0d, cycle %0d)", req, act, exp, pos, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      gap++;
      if (bclk_o != prev_bclk) begin
        if (gap_seen) check(gap == DIV, "R1 bit clock half period", gap, DIV);
        gap = 0;
        gap_seen = 1;
      end
      if (prev_bclk && !bclk_o && pos == 47) begin
        // frame load edge happened at posedge that made cyc current
        if (q.size() > 0 && q[0].c < cyc - 1) begin
          cur_l = q[0].l; cur_r = q[0].r; cur_el = q[0].el; cur_er = q[0].er;
          void'(q.pop_front());
          exp_und = 1'b0;
        end else begin
          exp_und = 1'b1;
        end
      end
      if (!prev_bclk && bclk_o) begin
        pos = (pos + 1) % 48;
        rise_cyc = cyc;
        check(sdata_o == exp_sd(cur_l, cur_r, pos), "R4 R5 R8 serial data",
              sdata_o, exp_sd(cur_l, cur_r, pos));
        check(lrck_o == exp_lr(pos), "R3 channel select", lrck_o, exp_lr(pos));
        check(errflag_o == exp_er(cur_el, cur_er, pos), "R6 error flag",
              errflag_o, exp_er(cur_el, cur_er, pos));
        check(underrun_o == exp_und, "R9 underrun", underrun_o, exp_und);
      end
      prev_bclk = bclk_o;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic send(logic [15:0] l, logic [15:0] r, logic el, logic er);
    ent_t e;
    in_left = l; in_right = r; in_err_left = el; in_err_right = er;
    in_valid = 1'b1;
    while (!in_ready) tick();
    e.l = l; e.r = r; e.el = el; e.er = er; e.c = cyc;
    q.push_back(e);
    tick();
    check(in_ready == 1'b0, "R7 ready drops after accept", in_ready, 0);
    in_valid = 1'b0;
  endtask

  task automatic wait_rise_at(int p);
    do tick(); while (!(pos == p && rise_cyc == cyc));
  endtask

  initial begin
    repeat (4) tick();
    // R11 reset state
    check(bclk_o == 0, "R11 reset bclk", bclk_o, 0);
    check(lrck_o == 1, "R11 reset lrck", lrck_o, 1);
    check(sdata_o == 0, "R11 reset sdata", sdata_o, 0);
    check(errflag_o == 0, "R11 reset errflag", errflag_o, 0);
    check(underrun_o == 0, "R11 reset underrun", underrun_o, 0);
    check(in_ready == 1, "R11 reset ready", in_ready, 1);
    rst = 1'b0;

    // directed corner values
    send(16'h8000, 16'h7FFF, 1'b1, 1'b0);
    send(16'hFFFF, 16'h0001, 1'b0, 1'b1);
    send(16'h5A5A, 16'hA5A5, 1'b1, 1'b1);
    send(16'h0000, 16'hFFFF, 1'b0, 1'b0);

    // random traffic, gaps sometimes longer than a frame
    void'($urandom(32'h1D5C));
    for (int i = 0; i < 60; i++) begin
      send(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
      repeat ($urandom_range(0, 260)) tick();
    end

    // starvation: several repeated frames
    repeat (700) tick();

    // R10: accept exactly on the frame load edge
    for (int k = 0; k < 3; k++) begin
      repeat (400) tick();
      wait_rise_at(47);
      repeat (DIV - 1) tick();
      send(16'hC3A0 + 16'(k), 16'h0F0F, 1'b1, 1'b0);
      wait_rise_at(0);
      check(underrun_o == 1'b1, "R10 collision frame repeats", underrun_o, 1);
      wait_rise_at(0);
      check(underrun_o == 1'b0, "R10 next frame fresh", underrun_o, 0);
      check(sdata_o == 1'b1, "R10 collision pair MSB", sdata_o, 1);
    end

    // back-to-back stream with no gaps
    for (int i = 0; i < 20; i++)
      send(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
    repeat (800) tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(10 * 190000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule